// File: doc/BRIEF.md
# Compressed-to-Wide Instruction Translator

This block is a purely combinational front-end stage. It takes one 16-bit compressed instruction and rewrites it as the equivalent 32-bit wide-format instruction, so that a single wide-format execution core can run code written in either encoding. Each dense two-address compressed format becomes a three-address wide word. The source register also serves as the destination. Every data-processing result updates the condition codes.

The supported formats are:
- the register and 3-bit-immediate add/subtract forms
- the 8-bit-immediate move/compare/add/subtract group
- the immediate shifts
- the conditional branch
- the unconditional branch
- the software interrupt

Any other pattern is reported as undefined and produces an all-zero word. This includes a branch whose half-word offset cannot be expressed in word units. The decode stage places the result in its own pipeline register.

Top module: `c2w_translator`

## Requirements
- R1: In the 8-bit-immediate group (bits[15:13]=001, op in [12:11], register in [10:8], imm8 in [7:0]), op 00/01/10/11 maps to wide opcode 1101 (move), 1010 (compare), 0100 (add) and 0010 (subtract). The wide word has bits[27:26]=00, immediate bit 25=1, rotate field [11:8]=0000 and the imm8 in [7:0].
- R2: In the immediate group, the register field goes to wide Rn [19:16] and Rd [15:12] for add and subtract. Move puts 0000 in Rn, and compare puts 0000 in Rd.
- R3: The register add/subtract form 000110 A Rm Rn Rd (A=bit 9, 1=subtract) maps to a wide add (0100) or subtract (0010) with bit 25=0, Rn and Rd copied, and Rm in [3:0] with [11:4]=0.
- R4: The 3-bit-immediate form 000111 A imm3 Rn Rd maps to a wide add or subtract with bit 25=1, rotate 0 and the zero-extended imm3 in [7:0].
- R5: An immediate shift (000, op in [12:11] with 00=left, 01=logical right, 10=arithmetic right, amount in [10:6], Rn in [5:3], Rd in [2:0]) becomes a wide move (1101, Rn=0000) of Rn. The amount is placed in [11:7], the shift type in [6:5], bit 4 is 0, and Rn is placed in [3:0].
- R6: A conditional branch 1101 cond off8 with cond 0000..1101 becomes {cond, 1010, off24}. Here off24 is the sign-extended half-word offset divided by two.
- R7: An unconditional branch 11100 off11 becomes {1110, 1010, off24}, with the same offset scaling as R6.
- R8: A branch whose half-word offset is odd is flagged undefined.
- R9: The software interrupt 11011111 imm8 becomes 0xEF000000 with the imm8 zero-extended into [23:0].
- R10: Any unsupported pattern, including cond 1110 in the conditional-branch slot, asserts undefined and drives the word to zero.
- R11: The valid output is always the inverse of the undefined output. Every valid word other than a conditional branch carries condition 1110.
- R12: Every translated data-processing word has the condition-update bit 20 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Compressed instruction word |
| word_o | output | 32 | Translated wide instruction, zero when undefined |
| valid_o | output | 1 | Translation succeeded |
| undef_o | output | 1 | Unsupported or unrepresentable instruction |

## Verification
All four immediate-group op values are driven with distinct registers and immediates. This tells apart the opcode table and the placement of the Rn and Rd fields, including the empty field for move and compare. Each shift type is driven, including a zero logical-right amount, to show that the amount and type are copied bit for bit. Branches are tried with positive, negative, extreme and odd offsets. These cases separate correct sign extension and scaling from plain truncation. The reserved condition, the long-branch prefix and several other opcodes are driven to confirm that undefined patterns drive the word to zero.

// File: rtl/c2w_pkg.sv
package c2w_pkg;
    localparam int CW = 16;
    localparam int WW = 32;
    localparam int OFFW = 24;
    localparam logic [3:0] COND_AL = 4'hE;

    localparam logic [3:0] OPC_MOV = 4'b1101;
    localparam logic [3:0] OPC_CMP = 4'b1010;
    localparam logic [3:0] OPC_ADD = 4'b0100;
    localparam logic [3:0] OPC_SUB = 4'b0010;

    typedef enum logic [2:0] {
        F_UNDEF, F_ADDSUB, F_SHIFT, F_IMM8, F_BCOND, F_BRANCH, F_SWI
    } fmt_e;

    typedef struct packed {
        logic [3:0]  opc;
        logic        imm;
        logic [3:0]  rn;
        logic [3:0]  rd;
        logic [11:0] op2;
    } dp_t;

    function automatic logic [WW-1:0] dp_word(input dp_t d);
        return {COND_AL, 2'b00, d.imm, d.opc, 1'b1, d.rn, d.rd, d.op2};
    endfunction

    function automatic logic is_dp(input fmt_e f);
        return (f == F_ADDSUB) || (f == F_SHIFT) || (f == F_IMM8);
    endfunction
endpackage

// File: rtl/c2w_classify.sv
module c2w_classify
    import c2w_pkg::*;
(
    input  logic [7:0] hi_i,
    output fmt_e       fmt_o
);
    always_comb begin
        if (hi_i[7:3] == 5'b00011)
            fmt_o = F_ADDSUB;
        else if (hi_i[7:5] == 3'b000)
            fmt_o = F_SHIFT;
        else if (hi_i[7:5] == 3'b001)
            fmt_o = F_IMM8;
        else if (hi_i[7:4] == 4'b1101) begin
            if (hi_i[3:0] == 4'hF)
                fmt_o = F_SWI;
            else if (hi_i[3:0] == 4'hE)
                fmt_o = F_UNDEF;
            else
                fmt_o = F_BCOND;
        end
        else if (hi_i[7:3] == 5'b11100)
            fmt_o = F_BRANCH;
        else
            fmt_o = F_UNDEF;
    end
endmodule

// File: rtl/c2w_dp_enc.sv
module c2w_dp_enc
    import c2w_pkg::*;
(
    input  logic [12:0]   bits_i,
    input  fmt_e          fmt_i,
    output logic [WW-1:0] word_o
);
    dp_t d;

    always_comb begin
        d = '0;
        case (fmt_i)
            F_IMM8: begin
                d.imm = 1'b1;
                d.op2 = {4'h0, bits_i[7:0]};
                case (bits_i[12:11])
                    2'b00: begin
                        d.opc = OPC_MOV;
                        d.rd  = {1'b0, bits_i[10:8]};
                    end
                    2'b01: begin
                        d.opc = OPC_CMP;
                        d.rn  = {1'b0, bits_i[10:8]};
                    end
                    2'b10: begin
                        d.opc = OPC_ADD;
                        d.rn  = {1'b0, bits_i[10:8]};
                        d.rd  = {1'b0, bits_i[10:8]};
                    end
                    default: begin
                        d.opc = OPC_SUB;
                        d.rn  = {1'b0, bits_i[10:8]};
                        d.rd  = {1'b0, bits_i[10:8]};
                    end
                endcase
            end
            F_ADDSUB: begin
                d.opc = bits_i[9] ? OPC_SUB : OPC_ADD;
                d.imm = bits_i[10];
                d.rn  = {1'b0, bits_i[5:3]};
                d.rd  = {1'b0, bits_i[2:0]};
                d.op2 = {9'b0, bits_i[8:6]};
            end
            F_SHIFT: begin
                d.opc = OPC_MOV;
                d.rd  = {1'b0, bits_i[2:0]};
                d.op2 = {bits_i[10:6], bits_i[12:11], 1'b0, 1'b0, bits_i[5:3]};
            end
            default: ;
        endcase
        word_o = dp_word(d);
    end

    // Data-processing words never touch the high register bank.
    always_comb begin
        if (is_dp(fmt_i))
            AST_DP_LOW_REGS: assert (word_o[19] == 1'b0 && word_o[15] == 1'b0)
                else $error("high register in dp word"); // R2
    end
endmodule

// File: rtl/c2w_br_enc.sv
module c2w_br_enc
    import c2w_pkg::*;
(
    input  logic [11:0]   bits_i,
    input  fmt_e          fmt_i,
    output logic [WW-1:0] word_o,
    output logic          unrep_o
);
    logic [OFFW-1:0] off_c;
    logic [OFFW-1:0] off_u;

    always_comb begin
        off_c = {{(OFFW-7){bits_i[7]}}, bits_i[7:1]};
        off_u = {{(OFFW-10){bits_i[10]}}, bits_i[10:1]};
        word_o  = '0;
        unrep_o = 1'b0;
        case (fmt_i)
            F_BCOND: begin
                word_o  = {bits_i[11:8], 4'b1010, off_c};
                unrep_o = bits_i[0];
            end
            F_BRANCH: begin
                word_o  = {COND_AL, 4'b1010, off_u};
                unrep_o = bits_i[0];
            end
            F_SWI: word_o = {COND_AL, 4'hF, 16'h0, bits_i[7:0]};
            default: ;
        endcase
    end

    // The top offset bit must agree with the sign bit of the short offset.
    always_comb begin
        if (fmt_i == F_BCOND)
            AST_BCOND_SIGN: assert (word_o[23] == bits_i[7])
                else $error("bad cond offset sign"); // R6
        if (fmt_i == F_BRANCH)
            AST_BRANCH_SIGN: assert (word_o[23] == bits_i[10])
                else $error("bad branch offset sign"); // R7
    end
endmodule

// File: rtl/c2w_translator.sv
module c2w_translator
    import c2w_pkg::*;
(
    input  logic [15:0] instr_i,
    output logic [31:0] word_o,
    output logic        valid_o,
    output logic        undef_o
);
    fmt_e          fmt;
    logic [WW-1:0] dp_w;
    logic [WW-1:0] br_w;
    logic          unrep;

    c2w_classify u_cls (
        .hi_i  (instr_i[15:8]),
        .fmt_o (fmt)
    );

    c2w_dp_enc u_dp (
        .bits_i (instr_i[12:0]),
        .fmt_i  (fmt),
        .word_o (dp_w)
    );

    c2w_br_enc u_br (
        .bits_i  (instr_i[11:0]),
        .fmt_i   (fmt),
        .word_o  (br_w),
        .unrep_o (unrep)
    );

    always_comb begin
        undef_o = (fmt == F_UNDEF) || unrep;
        valid_o = !undef_o;
        if (undef_o)
            word_o = '0;
        else if (is_dp(fmt))
            word_o = dp_w;
        else
            word_o = br_w;
    end

    always_comb begin
        AST_VALID_EXCL: assert (valid_o != undef_o)
            else $error("valid/undef clash"); // R11
        if (undef_o)
            AST_UNDEF_ZERO: assert (word_o == '0)
                else $error("undefined word not zero"); // R10
        if (valid_o && fmt != F_BCOND)
            AST_COND_ALWAYS: assert (word_o[31:28] == COND_AL)
                else $error("condition not always"); // R11
        if (valid_o && is_dp(fmt))
            AST_S_FORCED: assert (word_o[20] && word_o[27:26] == 2'b00)
                else $error("S bit not forced"); // R12
    end
endmodule

// File: tb/c2w_translator_bench.sv
module c2w_translator_bench;
    logic        clk = 1'b0;
    logic [15:0] instr;
    logic [31:0] word;
    logic        valid;
    logic        undef;
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    c2w_translator u_c2w_translator (
        .instr_i (instr),
        .word_o  (word),
        .valid_o (valid),
        .undef_o (undef)
    );

    task automatic check(input logic [15:0] in, input logic [31:0] exp_w,
                         input logic exp_v, input string req);
        @(posedge clk);
        instr = in;
        @(negedge clk);
        n_chk++;
        if (word !== exp_w || valid !== exp_v || undef !== !exp_v) begin
            n_fail++;
            $display("FAIL %s in=%h word=%h exp=%h valid=%b exp=%b undef=%b",
                     req, in, word, exp_w, valid, exp_v, undef);
        end
    endtask

    task automatic t_reset_state;
        // R5: all-zero input is LSL r0,r0,#0
        check(16'h0000, 32'hE1B00000, 1'b1, "R5 zero");
    endtask

    task automatic t_imm8;
        check(16'h235A, 32'hE3B0305A, 1'b1, "R1 R2 mov");
        check(16'h2D80, 32'hE3550080, 1'b1, "R1 R2 cmp");
        check(16'h3211, 32'hE2922011, 1'b1, "R1 R12 add");
        check(16'h3FFF, 32'hE25770FF, 1'b1, "R1 sub");
    endtask

    task automatic t_addsub;
        check(16'h18D1, 32'hE0921003, 1'b1, "R3 add reg");
        check(16'h1A51, 32'hE0521001, 1'b1, "R3 sub reg");
        check(16'h1FAC, 32'hE2554006, 1'b1, "R4 sub imm3");
        check(16'h1C48, 32'hE2910001, 1'b1, "R4 add imm3");
    endtask

    task automatic t_shift;
        check(16'h0148, 32'hE1B00281, 1'b1, "R5 lsl");
        check(16'h17FE, 32'hE1B06FC7, 1'b1, "R5 asr");
        check(16'h081A, 32'hE1B02023, 1'b1, "R5 lsr0");
    endtask

    task automatic t_branch;
        check(16'hD004, 32'h0A000002, 1'b1, "R6 beq fwd");
        check(16'hD1FC, 32'h1AFFFFFE, 1'b1, "R6 bne back");
        check(16'hDD80, 32'hDAFFFFC0, 1'b1, "R6 min");
        check(16'hE7FE, 32'hEAFFFFFF, 1'b1, "R7 back");
        check(16'hE3FE, 32'hEA0001FF, 1'b1, "R7 max");
        check(16'hD003, 32'h00000000, 1'b0, "R8 odd cond");
        check(16'hE001, 32'h00000000, 1'b0, "R8 odd uncond");
    endtask

    task automatic t_swi;
        check(16'hDFAB, 32'hEF0000AB, 1'b1, "R9 swi");
        check(16'hDF00, 32'hEF000000, 1'b1, "R9 swi0");
    endtask

    task automatic t_undef;
        check(16'hDE00, 32'h00000000, 1'b0, "R10 cond1110");
        check(16'h4000, 32'h00000000, 1'b0, "R10 alu");
        check(16'hF000, 32'h00000000, 1'b0, "R10 long");
        check(16'hC000, 32'h00000000, 1'b0, "R10 multi");
        check(16'hE800, 32'h00000000, 1'b0, "R11 e8");
    endtask

    initial begin
        instr = 16'h0000;
        t_reset_state();
        t_imm8();
        t_addsub();
        t_shift();
        t_branch();
        t_swi();
        t_undef();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule